// File: doc/BRIEF.md
# I/O Channel Program Sequencer

The block is a small I/O coprocessor that runs a chained program of command words kept in shared memory. A host first loads a program start address into the channel address word register, then pulses a start command. The channel reads each 64-bit command through a byte-wide memory read/write port, on which it steals cycles whenever the port grants it, and then carries out the command. A command can move a block of bytes between memory and one attached device through a valid/ready byte handshake, send a control byte to the device, transfer control to another address, do nothing, or end the program.

When the program stops, the channel writes a status word and pulses an interrupt. The host then reads the status word, the command register and the address register from the block's outputs. A start that arrives while a program is running is refused with a one-cycle busy response and leaves the running program untouched.

Top module: `chan_seq`

## Requirements
- R1: After reset `busy_o`, `irq_o`, `start_ack_o`, `start_busy_o` and `mem_req_o` are 0, and `csw_o` and `caw_o` are 0.
- R2: While idle, `caw_we_i` loads `caw_wdata_i` into the address word, and `caw_o` shows it one cycle later.
- R3: `start_i` while idle makes `busy_o` rise. The channel then fetches the command at the address word as 8 bytes from consecutive addresses, least significant byte first, and pulses `start_ack_o` for one cycle once the first command is in the command register. The memory port makes no request while the channel is idle.
- R4: A write command (opcode 2) reads `count` bytes from memory starting at the command's address and presents them in ascending address order on `dev_wr_data_o`. The valid signal and the data hold until `dev_wr_ready_i` is seen.
- R5: A read command (opcode 1) takes `count` bytes from the device handshake and stores them to memory at ascending addresses starting at the command's address.
- R6: Command word layout: opcode in bits 3:0, chain flag in bit 4, byte count in bits 23:8, memory address in bits 63:32. After a nop, read, write or control command, a chain flag of 1 continues with the command at the next 8-byte address, and a chain flag of 0 ends the program. The address word does not change while data moves.
- R7: A branch command (opcode 4) loads its address field into the address word and continues from there whatever its chain flag. It moves no data.
- R8: An end command (opcode 5) stops the program. A nop (opcode 0) moves nothing. A control command (opcode 3) raises `dev_ctl_valid_o` for exactly one cycle with `dev_ctl_o` equal to bits 7:0 of its address field.
- R9: At completion `irq_o` pulses for one cycle and `busy_o` is low. `csw_o` then holds bit 0 = 1 (done), bits 7:4 = opcode of the last command, and bits 15:8 = number of commands executed in the program. `ccw_o` holds the last command and `caw_o` holds that command's address plus 8.
- R10: An opcode above 5 sets `csw_o` bit 1. A read or write with a byte count of 0 sets `csw_o` bit 2. Either one ends the program with the interrupt and moves no data.
- R11: `start_i` while busy gives a one-cycle `start_busy_o` pulse on the next cycle and no second acknowledge. That start, and any `caw_we_i` while busy, leave the running program's results unchanged.
- R12: `mem_req_o`, `mem_we_o` and `mem_addr_o` hold until `mem_gnt_i` is seen. Read data on `mem_rdata_i` is taken in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| caw_we_i | input | 1 | Load the address word |
| caw_wdata_i | input | 32 | Program start address |
| start_i | input | 1 | Start command |
| start_ack_o | output | 1 | Start accepted, first command fetched |
| start_busy_o | output | 1 | Start refused, channel busy |
| busy_o | output | 1 | Program running |
| irq_o | output | 1 | Program finished pulse |
| caw_o | output | 32 | Address word |
| ccw_o | output | 64 | Current command word |
| csw_o | output | 32 | Status word |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_gnt_i | input | 1 | Memory cycle granted |
| mem_rdata_i | input | 8 | Memory read byte, cycle after grant |
| dev_rd_valid_i | input | 1 | Device byte available |
| dev_rd_data_i | input | 8 | Device byte |
| dev_rd_ready_o | output | 1 | Channel takes device byte |
| dev_wr_valid_o | output | 1 | Byte for device available |
| dev_wr_data_o | output | 8 | Byte for device |
| dev_wr_ready_i | input | 1 | Device takes byte |
| dev_ctl_valid_o | output | 1 | Control byte strobe |
| dev_ctl_o | output | 8 | Control byte |

## Verification
A wrong fetch index or address-word update shows at the ports within one program. The wrong bytes reach the device or memory, or `caw_o` and the command count in `csw_o` are off when the interrupt fires. A broken decode shows as the wrong error bits or a missing control strobe in the same interrupt cycle. A mover whose count or address slips shows as a short or shifted byte stream well before completion. Random programs with random grant and handshake stalls are compared byte for byte with a program interpreter in the bench.

// File: rtl/chan_pkg.sv
package chan_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned CMD_W   = 64;
  localparam int unsigned CMD_BYTES = CMD_W / BYTE_W;
  localparam int unsigned STAT_W  = 32;

  localparam logic [OP_W-1:0] OP_NOP    = 4'd0;
  localparam logic [OP_W-1:0] OP_READ   = 4'd1;
  localparam logic [OP_W-1:0] OP_WRITE  = 4'd2;
  localparam logic [OP_W-1:0] OP_CTRL   = 4'd3;
  localparam logic [OP_W-1:0] OP_BRANCH = 4'd4;
  localparam logic [OP_W-1:0] OP_END    = 4'd5;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [7:0]        rsv_hi;
    logic [CNT_W-1:0]  count;
    logic [2:0]        rsv_lo;
    logic              chain;
    logic [OP_W-1:0]   op;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_EXEC, S_XFER, S_FIN
  } seq_state_e;

  typedef enum logic [2:0] {
    M_IDLE, M_MRD, M_MWAIT, M_DOUT, M_DIN, M_MWR
  } mov_state_e;
endpackage

// File: rtl/chan_decode.sv
module chan_decode
  import chan_pkg::*;
(
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [OP_W-1:0]   op_o,
  output logic              chain_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_move_o,
  output logic              op_bad_o,
  output logic              cnt_zero_o
);
  cmd_t c;
  assign c          = cmd_t'(cmd_i);
  assign op_o       = c.op;
  assign chain_o    = c.chain;
  assign count_o    = c.count;
  assign addr_o     = c.addr;
  assign is_move_o  = (c.op == OP_READ) || (c.op == OP_WRITE);
  assign op_bad_o   = c.op > OP_END;
  assign cnt_zero_o = is_move_o && (c.count == '0);
endmodule

// File: rtl/chan_mover.sv
module chan_mover
  import chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              to_mem_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              dev_rd_valid_i,
  input  logic [BYTE_W-1:0] dev_rd_data_i,
  output logic              dev_rd_ready_o,
  output logic              dev_wr_valid_o,
  output logic [BYTE_W-1:0] dev_wr_data_o,
  input  logic              dev_wr_ready_i
);
  mov_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [BYTE_W-1:0] buf_q;
  logic              step;
  logic              last;

  assign mem_req_o      = (st_q == M_MRD) || (st_q == M_MWR);
  assign mem_we_o       = (st_q == M_MWR);
  assign mem_addr_o     = addr_q;
  assign mem_wdata_o    = buf_q;
  assign dev_rd_ready_o = (st_q == M_DIN);
  assign dev_wr_valid_o = (st_q == M_DOUT);
  assign dev_wr_data_o  = buf_q;

  // one byte retired this cycle
  assign step   = ((st_q == M_DOUT) && dev_wr_ready_i) || ((st_q == M_MWR) && mem_gnt_i);
  assign last   = (left_q == CNT_W'(1));
  assign done_o = step && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      addr_q <= '0;
      left_q <= '0;
      buf_q  <= '0;
    end else begin
      if (step) begin
        addr_q <= addr_q + ADDR_W'(1);
        left_q <= left_q - CNT_W'(1);
      end
      unique case (st_q)
        M_IDLE: if (go_i) begin
          addr_q <= addr_i;
          left_q <= count_i;
          st_q   <= to_mem_i ? M_DIN : M_MRD;
        end
        M_MRD:   if (mem_gnt_i) st_q <= M_MWAIT;
        M_MWAIT: begin
          buf_q <= mem_rdata_i;
          st_q  <= M_DOUT;
        end
        M_DOUT:  if (dev_wr_ready_i) st_q <= last ? M_IDLE : M_MRD;
        M_DIN:   if (dev_rd_valid_i) begin
          buf_q <= dev_rd_data_i;
          st_q  <= M_MWR;
        end
        M_MWR:   if (mem_gnt_i) st_q <= last ? M_IDLE : M_DIN;
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assert_wr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_wr_valid_o && !dev_wr_ready_i |=> dev_wr_valid_o && $stable(dev_wr_data_o));

  assert_left_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != M_IDLE) |-> (left_q != '0));

  assert_wr_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_req_o && !mem_gnt_i |=> mem_we_o && $stable(mem_wdata_o));
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import chan_pkg::*;
#(
  parameter int unsigned CMD_CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              caw_we_i,
  input  logic [31:0]       caw_wdata_i,
  input  logic              start_i,
  output logic              start_ack_o,
  output logic              start_busy_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [31:0]       caw_o,
  output logic [63:0]       ccw_o,
  output logic [31:0]       csw_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [7:0]        mem_rdata_i,
  input  logic              dev_rd_valid_i,
  input  logic [7:0]        dev_rd_data_i,
  output logic              dev_rd_ready_o,
  output logic              dev_wr_valid_o,
  output logic [7:0]        dev_wr_data_o,
  input  logic              dev_wr_ready_i,
  output logic              dev_ctl_valid_o,
  output logic [7:0]        dev_ctl_o
);
  localparam int unsigned IDX_W  = $clog2(CMD_BYTES);
  localparam int unsigned PAD_W  = STAT_W - CMD_CNT_W - OP_W - 4;

  seq_state_e         st_q;
  logic [ADDR_W-1:0]  caw_q;
  logic [CMD_W-1:0]   ccw_q;
  logic [STAT_W-1:0]  csw_q;
  logic [IDX_W-1:0]   fidx_q;
  logic [CMD_CNT_W-1:0] ncmd_q;
  logic first_q, operr_q, cnterr_q, irq_q, ack_q, bsy_q;

  logic [OP_W-1:0]   d_op;
  logic              d_chain, d_move, d_bad, d_zero;
  logic [CNT_W-1:0]  d_count;
  logic [ADDR_W-1:0] d_addr;

  logic              mv_go, mv_done, mv_req, mv_we;
  logic [ADDR_W-1:0] mv_addr;
  logic [BYTE_W-1:0] mv_wdata;
  logic              fetch_req;

  chan_decode u_dec (
    .cmd_i(ccw_q), .op_o(d_op), .chain_o(d_chain), .count_o(d_count),
    .addr_o(d_addr), .is_move_o(d_move), .op_bad_o(d_bad), .cnt_zero_o(d_zero)
  );

  assign mv_go = (st_q == S_EXEC) && d_move && !d_zero;

  chan_mover u_mov (
    .clk_i, .rst_ni, .go_i(mv_go), .to_mem_i(d_op == OP_READ),
    .addr_i(d_addr), .count_i(d_count), .done_o(mv_done),
    .mem_req_o(mv_req), .mem_we_o(mv_we), .mem_addr_o(mv_addr), .mem_wdata_o(mv_wdata),
    .mem_gnt_i, .mem_rdata_i,
    .dev_rd_valid_i, .dev_rd_data_i, .dev_rd_ready_o,
    .dev_wr_valid_o, .dev_wr_data_o, .dev_wr_ready_i
  );

  // command fetch and data moves share one port; they never overlap in time
  assign fetch_req   = (st_q == S_FETCH);
  assign mem_req_o   = fetch_req || mv_req;
  assign mem_we_o    = !fetch_req && mv_we;
  assign mem_addr_o  = fetch_req ? caw_q + ADDR_W'(fidx_q) : mv_addr;
  assign mem_wdata_o = mv_wdata;

  assign dev_ctl_valid_o = (st_q == S_EXEC) && (d_op == OP_CTRL);
  assign dev_ctl_o       = d_addr[7:0];

  assign busy_o       = (st_q != S_IDLE);
  assign irq_o        = irq_q;
  assign start_ack_o  = ack_q;
  assign start_busy_o = bsy_q;
  assign caw_o        = caw_q;
  assign ccw_o        = ccw_q;
  assign csw_o        = csw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      caw_q    <= '0;
      ccw_q    <= '0;
      csw_q    <= '0;
      fidx_q   <= '0;
      ncmd_q   <= '0;
      first_q  <= 1'b0;
      operr_q  <= 1'b0;
      cnterr_q <= 1'b0;
      irq_q    <= 1'b0;
      ack_q    <= 1'b0;
      bsy_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      ack_q <= 1'b0;
      bsy_q <= start_i && (st_q != S_IDLE);
      unique case (st_q)
        S_IDLE: begin
          if (start_i) begin
            st_q     <= S_FETCH;
            fidx_q   <= '0;
            first_q  <= 1'b1;
            ncmd_q   <= '0;
            operr_q  <= 1'b0;
            cnterr_q <= 1'b0;
          end else if (caw_we_i) begin
            caw_q <= caw_wdata_i;
          end
        end
        S_FETCH: if (mem_gnt_i) st_q <= S_FWAIT;
        S_FWAIT: begin
          ccw_q[fidx_q*BYTE_W +: BYTE_W] <= mem_rdata_i;
          fidx_q <= fidx_q + IDX_W'(1);
          if (fidx_q == IDX_W'(CMD_BYTES-1)) begin
            caw_q   <= caw_q + ADDR_W'(CMD_BYTES);
            st_q    <= S_EXEC;
            ack_q   <= first_q;
            first_q <= 1'b0;
          end else begin
            st_q <= S_FETCH;
          end
        end
        S_EXEC: begin
          ncmd_q <= ncmd_q + CMD_CNT_W'(1);
          if (d_bad) begin
            operr_q <= 1'b1;
            st_q    <= S_FIN;
          end else if (d_zero) begin
            cnterr_q <= 1'b1;
            st_q     <= S_FIN;
          end else if (d_move) begin
            st_q <= S_XFER;
          end else if (d_op == OP_BRANCH) begin
            caw_q <= d_addr;
            st_q  <= S_FETCH;
          end else if (d_op == OP_END) begin
            st_q <= S_FIN;
          end else begin
            st_q <= d_chain ? S_FETCH : S_FIN;
          end
        end
        S_XFER: if (mv_done) st_q <= d_chain ? S_FETCH : S_FIN;
        S_FIN: begin
          csw_q <= {PAD_W'(0), ncmd_q, d_op, 1'b0, cnterr_q, operr_q, 1'b1};
          irq_q <= 1'b1;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_idle_no_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  assert_ack_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ack_o |-> busy_o);

  assert_caw_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_XFER) && !mv_done |=> $stable(caw_q));

  assert_ctl_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ctl_valid_o |=> !dev_ctl_valid_o);

  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> csw_o[0] && !busy_o);

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

// File: tb/chan_seq_bench.sv
`timescale 1ns/1ps
module chan_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        caw_we = 0, start = 0;
  logic [31:0] caw_wdata = 0;
  logic        start_ack, start_busy, busy, irq;
  logic [31:0] caw, csw, mem_addr;
  logic [63:0] ccw;
  logic        mem_req, mem_we, mem_gnt = 0;
  logic [7:0]  mem_wdata, mem_rdata = 0;
  logic        dev_rd_valid = 0, dev_rd_ready, dev_wr_valid, dev_wr_ready = 0;
  logic [7:0]  dev_rd_data = 0, dev_wr_data, dev_ctl;
  logic        dev_ctl_valid;

  chan_seq u_chan_seq (
    .clk_i(clk), .rst_ni(rst_n), .caw_we_i(caw_we), .caw_wdata_i(caw_wdata),
    .start_i(start), .start_ack_o(start_ack), .start_busy_o(start_busy),
    .busy_o(busy), .irq_o(irq), .caw_o(caw), .ccw_o(ccw), .csw_o(csw),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .dev_rd_valid_i(dev_rd_valid), .dev_rd_data_i(dev_rd_data), .dev_rd_ready_o(dev_rd_ready),
    .dev_wr_valid_o(dev_wr_valid), .dev_wr_data_o(dev_wr_data), .dev_wr_ready_i(dev_wr_ready),
    .dev_ctl_valid_o(dev_ctl_valid), .dev_ctl_o(dev_ctl)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] mem [0:1023];
  logic [7:0] em  [0:1023];
  logic [7:0] outb [0:1023];
  logic [7:0] eout [0:1023];
  int out_n, ctl_n, ack_n, bsyp_n, irq_n, src_idx = 0;
  logic [7:0]  ctl_last;
  logic [31:0] cap_csw, cap_caw;
  logic [63:0] cap_ccw;
  int eout_n, ectl_n;
  logic [7:0]  ectl_last;
  logic [31:0] ecsw, ecaw;
  logic [63:0] eccw;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] src_byte(input int i);
    return 8'(i * 29 + 7) ^ 8'(i >> 3);
  endfunction

  function automatic logic [63:0] mk(input logic [3:0] op, input bit chain,
                                     input logic [15:0] cnt, input logic [31:0] addr);
    return {addr, 8'h00, cnt, 3'b000, chain, op};
  endfunction

  task automatic put_cmd(input int a, input logic [63:0] c);
    for (int i = 0; i < 8; i++) mem[(a + i) % 1024] = c[i*8 +: 8];
  endtask

  // interpreter of the command program on a private memory copy
  task automatic predict(input logic [31:0] start_pc);
    logic [31:0] pc;
    logic [63:0] c;
    logic [3:0]  op;
    logic [15:0] cn;
    logic [31:0] ad;
    int k, ncmd;
    bit stop, operr, cnterr;
    for (int i = 0; i < 1024; i++) em[i] = mem[i];
    pc = start_pc; k = src_idx; ncmd = 0; stop = 0; operr = 0; cnterr = 0;
    eout_n = 0; ectl_n = 0; ectl_last = 0;
    for (int step = 0; step < 64 && !stop; step++) begin
      for (int i = 0; i < 8; i++) c[i*8 +: 8] = em[(pc + i) % 1024];
      pc = pc + 8; ncmd++;
      op = c[3:0]; cn = c[23:8]; ad = c[63:32];
      if (op > 4'd5) begin operr = 1; stop = 1; end
      else if ((op == 4'd1 || op == 4'd2) && cn == 0) begin cnterr = 1; stop = 1; end
      else begin
        case (op)
          4'd1: for (int j = 0; j < cn; j++) begin em[(ad + j) % 1024] = src_byte(k); k++; end
          4'd2: for (int j = 0; j < cn; j++) begin eout[eout_n] = em[(ad + j) % 1024]; eout_n++; end
          4'd3: begin ectl_n++; ectl_last = ad[7:0]; end
          default: ;
        endcase
        if (op == 4'd4) pc = ad;
        else if (op == 4'd5) stop = 1;
        else if (!c[4]) stop = 1;
      end
      eccw = c;
    end
    ecaw = pc;
    ecsw = {16'd0, 8'(ncmd), eccw[3:0], 1'b0, cnterr, operr, 1'b1};
  endtask

  // memory, device and port monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      mem_gnt = ($urandom % 4) != 0;
      if (mem_req && mem_gnt) begin
        if (mem_we) mem[mem_addr % 1024] = mem_wdata;
        else        mem_rdata = mem[mem_addr % 1024];
      end
      dev_wr_ready = ($urandom % 3) != 0;
      if (dev_wr_valid && dev_wr_ready) begin outb[out_n % 1024] = dev_wr_data; out_n++; end
      dev_rd_valid = ($urandom % 3) != 0;
      dev_rd_data  = src_byte(src_idx);
      if (dev_rd_ready && dev_rd_valid) src_idx++;
      if (dev_ctl_valid) begin ctl_n++; ctl_last = dev_ctl; end
      if (start_ack) ack_n++;
      if (start_busy) bsyp_n++;
      if (irq) begin irq_n++; cap_csw = csw; cap_caw = caw; cap_ccw = ccw; end
    end
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_prog(input logic [31:0] pc, input bit inject, input string tag);
    int t;
    predict(pc);
    out_n = 0; ctl_n = 0; ack_n = 0; bsyp_n = 0; irq_n = 0;
    @(negedge clk); caw_we = 1; caw_wdata = pc;
    @(negedge clk); caw_we = 0;
    chk(caw == pc, {"R2 caw load ", tag}, caw, pc);
    start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, {"R3 busy after start ", tag}, busy, 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      start = 1; caw_we = 1; caw_wdata = 32'h3F0;
      @(negedge clk); start = 0; caw_we = 0;
    end
    t = 0;
    while (irq_n == 0 && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(irq_n == 1, {"R9 one irq ", tag}, irq_n, 1);
    chk(busy == 1'b0, {"R9 idle after irq ", tag}, busy, 0);
    chk(ack_n == 1, {"R3 single start ack ", tag}, ack_n, 1);
    chk(cap_csw == ecsw, {"R9 R10 status word ", tag}, cap_csw, ecsw);
    chk(cap_caw == ecaw, {"R6 R7 address word ", tag}, cap_caw, ecaw);
    chk(cap_ccw == eccw, {"R9 command word ", tag}, cap_ccw, eccw);
    chk(out_n == eout_n, {"R4 device byte count ", tag}, out_n, eout_n);
    begin
      int bad = 0;
      for (int i = 0; i < eout_n && i < out_n; i++) if (outb[i] != eout[i]) bad++;
      chk(bad == 0, {"R4 device bytes ", tag}, bad, 0);
      bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] != em[i]) bad++;
      chk(bad == 0, {"R5 memory image ", tag}, bad, 0);
    end
    chk(ctl_n == ectl_n, {"R8 control strobes ", tag}, ctl_n, ectl_n);
    if (ectl_n > 0) chk(ctl_last == ectl_last, {"R8 control byte ", tag}, ctl_last, ectl_last);
    if (inject) chk(bsyp_n == 1, {"R11 busy refusal ", tag}, bsyp_n, 1);
  endtask

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && irq == 0 && start_ack == 0 && start_busy == 0, "R1 reset flags",
        {busy, irq, start_ack, start_busy}, 0);
    chk(csw == 0 && caw == 0, "R1 reset registers", {csw, caw}, 0);
    chk(mem_req == 0, "R1 no request in reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R1 R3 idle after reset", {busy, mem_req}, 0);

    // single write command, chain 0
    put_cmd(0, mk(4'd2, 0, 16'd5, 32'd260));
    run_prog(0, 0, "single write");

    // branch skips a bad command, then control and end
    put_cmd(0,   mk(4'd2, 1, 16'd3, 32'd300));
    put_cmd(8,   mk(4'd4, 0, 16'd0, 32'd128));
    put_cmd(16,  mk(4'd9, 1, 16'd0, 32'd0));
    put_cmd(128, mk(4'd3, 1, 16'd0, 32'h5A));
    put_cmd(136, mk(4'd5, 0, 16'd0, 32'd0));
    run_prog(0, 0, "R7 branch");

    // bad opcode after nop: R10
    put_cmd(64, mk(4'd0, 1, 16'd0, 32'd0));
    put_cmd(72, mk(4'd9, 1, 16'd4, 32'd520));
    run_prog(64, 0, "R10 bad opcode");

    // zero count read: R10
    put_cmd(96, mk(4'd1, 1, 16'd0, 32'd600));
    put_cmd(104, mk(4'd2, 0, 16'd2, 32'd256));
    run_prog(96, 0, "R10 zero count");

    // busy start and address write while running: R11
    put_cmd(160, mk(4'd2, 1, 16'd8, 32'd400));
    put_cmd(168, mk(4'd1, 1, 16'd8, 32'd700));
    put_cmd(176, mk(4'd0, 0, 16'd0, 32'd0));
    run_prog(160, 1, "R11 busy start");

    // end with chain set still stops: R8
    put_cmd(200, mk(4'd5, 1, 16'd3, 32'd0));
    put_cmd(208, mk(4'd2, 0, 16'd3, 32'd256));
    run_prog(200, 0, "R8 end");

    // random chained programs
    for (int r = 0; r < 20; r++) begin
      int n, base;
      n = 1 + ($urandom % 5);
      base = (r % 4) * 48;
      for (int k = 0; k < n; k++) begin
        logic [3:0] op;
        logic [31:0] ad;
        case ($urandom % 5)
          0: op = 4'd0; 1: op = 4'd1; 2: op = 4'd2; 3: op = 4'd3;
          default: op = (k == n - 1) ? 4'd5 : 4'd2;
        endcase
        if (op == 4'd1) ad = 512 + ((r * 5 + k) % 16) * 16;
        else if (op == 4'd3) ad = $urandom;
        else ad = 256 + ((r + k) % 16) * 16;
        put_cmd(base + k * 8, mk(op, k < n - 1, 16'(1 + $urandom % 8), ad));
      end
      run_prog(base, r % 7 == 3, "R4 R5 R6 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule